// File: doc/BRIEF.md
# Burst Address Counter with Read-Back

This block produces the word address for one port of a synchronous dual-port memory. The address is held in a register. It can be cleared, loaded from the external address bus, or advanced once per rising clock edge while counting is enabled. Once the counter is running, the counter value drives the array address instead of the external bus. Each port of a memory instantiates its own copy, and the copies share no state.

The counter is paired with a lane sequencer for ports whose data bus is narrower than the 36-bit word. The word is split into four 9-bit lanes. In half-width mode the sequencer walks through two 18-bit halves, and in quarter-width mode it walks through four 9-bit lanes, in ascending or descending order. The word address moves on only after the last sub-word of the current word has been passed. While the read-back mode is active, the counter is frozen and its value is returned on the data output in place of the memory data.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `addr_out` becomes 0 and `lane_out` becomes the start lane of the selected width and order.
- R2: `cnt_clr_n` low at a rising edge sets `addr_out` to 0 and `lane_out` to the start lane. This takes priority over load and over counting.
- R3: With `cnt_clr_n` high, `ld_n` low at a rising edge sets `addr_out` to `addr_in` and `lane_out` to the start lane. Load takes priority over counting.
- R4: In full-width mode (`bus_mode` = 0, or the unused code 3), each rising edge with `cnt_en_n` low, no clear, no load and `rdback` low raises `addr_out` by one. 0x3FFF wraps to 0x0000. `lane_out` stays 0.
- R5: With `cnt_clr_n`, `ld_n` and `cnt_en_n` all high, `addr_out` and `lane_out` keep their values.
- R6: While `rdback` is high, counting is suppressed and `data_out` equals `addr_out` in bits [13:0] with bits [35:14] zero.
- R7: While `rdback` is low, `data_out` equals `mem_q`.
- R8: In half-width mode (`bus_mode` = 1) with `big_end` low, counting steps `lane_out` 0 then 2. The step after lane 2 returns to lane 0 and raises `addr_out` by one.
- R9: In quarter-width mode (`bus_mode` = 2) with `big_end` low, counting steps `lane_out` 0, 1, 2, 3. The step after lane 3 returns to lane 0 and raises `addr_out` by one.
- R10: With `big_end` high, the order is reversed. Half width runs 2 then 0, and quarter width runs 3, 2, 1, 0, and the address advances after lane 0. In full-width mode `big_end` has no effect.
- R11: A clear or a load in the middle of a sub-word sequence restarts `lane_out` at the start lane for the current width and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | 14 | External word address to be loaded |
| ld_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| cnt_clr_n | input | 1 | Counter clear, active low |
| rdback | input | 1 | Hold-and-read mode, active high |
| bus_mode | input | 2 | Data width: 0 full, 1 half, 2 quarter, 3 treated as full; static outside reset |
| big_end | input | 1 | 1 selects descending sub-word order; static outside reset |
| mem_q | input | 36 | Data word read from the array |
| addr_out | output | 14 | Word address presented to the array |
| lane_out | output | 2 | Lowest 9-bit lane of the current sub-word |
| data_out | output | 36 | Data bus: array data, or the counter value in read-back mode |

## Verification
The counter is run in every width and order combination. Long runs of count enable cross several word boundaries, which separates a sequencer that advances the address at the right lane from one that is off by one sub-word. Clear, load and enable are asserted together in various combinations to expose a wrong priority order. A load just below 0x3FFF followed by counting exercises the wrap. Read-back phases keep count enable low and change `mem_q`, which shows both the freeze and the data selection.

// File: rtl/burst_addr_pkg.sv
// Package: shared encodings for the burst address generator.
// Assumes bus width is static except while reset is held.
package burst_addr_pkg;

    typedef enum logic [1:0] {
        BW_FULL    = 2'd0,
        BW_HALF    = 2'd1,
        BW_QUARTER = 2'd2,
        BW_RSVD    = 2'd3
    } bus_width_e;

endpackage

// File: rtl/lane_seq.sv
// Module: lane_seq
// Works out the start lane, last-lane flag and following lane of the
// sub-word sequencer from the bus width and order. Purely combinational.
// Assumes LANES is a power of two and at least 4.
module lane_seq
    import burst_addr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [1:0]        width_sel,
    input  logic              big_end,
    input  logic [LANE_W-1:0] lane_q,
    output logic [LANE_W-1:0] start_lane,
    output logic              last_lane,
    output logic [LANE_W-1:0] next_lane
);

    localparam logic [LANE_W-1:0] HALF_STRIDE = LANE_W'(LANES / 2);
    localparam logic [LANE_W-1:0] QTR_STRIDE  = LANE_W'(LANES / 4);

    logic [LANE_W-1:0] stride;
    logic [LANE_W-1:0] top_lane;

    // Lane stride for each width; zero marks the full-width bus.
    always_comb begin
        case (bus_width_e'(width_sel))
            BW_HALF:    stride = HALF_STRIDE;
            BW_QUARTER: stride = QTR_STRIDE;
            default:    stride = '0;
        endcase
    end

    // Highest sub-word lane: LANES - stride, computed modulo 2**LANE_W.
    assign top_lane = '0 - stride;

    // Start, last and next lane for the selected order.
    always_comb begin
        if (stride == '0) begin
            start_lane = '0;
            last_lane  = 1'b1;
            next_lane  = '0;
        end else if (big_end) begin
            start_lane = top_lane;
            last_lane  = (lane_q == '0);
            next_lane  = lane_q - stride;
        end else begin
            start_lane = '0;
            last_lane  = (lane_q == top_lane);
            next_lane  = lane_q + stride;
        end
    end

endmodule

// File: rtl/burst_ctr.sv
// Module: burst_ctr
// Word address register and lane register. Priority: reset/clear, then
// load, then advance. The lane steps, and the address advances only
// after the last lane. Assumes inc is already gated by read-back.
module burst_ctr #(
    parameter int ADDR_W = 14,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_n,
    input  logic              inc,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LANE_W-1:0] start_lane,
    input  logic              last_lane,
    input  logic [LANE_W-1:0] next_lane,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANE_W-1:0] lane_q
);

    // State update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            addr_q <= '0;
            lane_q <= start_lane;
        end else if (!ld_n) begin
            addr_q <= ld_addr;
            lane_q <= start_lane;
        end else if (inc) begin
            if (last_lane) begin
                addr_q <= addr_q + 1'b1;
                lane_q <= start_lane;
            end else begin
                lane_q <= next_lane;
            end
        end
    end

endmodule

// File: rtl/rdback_mux.sv
// Module: rdback_mux
// Selects the data bus source: array data, or the zero-extended counter
// value in read-back mode. Assumes DATA_W > ADDR_W.
module rdback_mux #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 36
) (
    input  logic              rdback,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] mem_q,
    output logic [DATA_W-1:0] data_out
);

    localparam int PAD_W = DATA_W - ADDR_W;

    // Output source select.
    always_comb begin
        if (rdback) data_out = {{PAD_W{1'b0}}, addr_q};
        else        data_out = mem_q;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Per-port burst address counter with sub-word lane sequencing and a
// hold-and-read mode. Assumes bus_mode and big_end change only in reset.
module burst_addr_gen #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ld_n,
    input  logic              cnt_en_n,
    input  logic              cnt_clr_n,
    input  logic              rdback,
    input  logic [1:0]        bus_mode,
    input  logic              big_end,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LANE_W-1:0] lane_out,
    output logic [DATA_W-1:0] data_out
);

    logic [LANE_W-1:0] start_lane;
    logic [LANE_W-1:0] next_lane;
    logic              last_lane;
    logic              inc;

    // Counting is suppressed while the counter is being read back.
    assign inc = !cnt_en_n && !rdback;

    lane_seq #(.LANES(LANES), .LANE_W(LANE_W)) i_lane_seq (
        .width_sel (bus_mode),
        .big_end   (big_end),
        .lane_q    (lane_out),
        .start_lane(start_lane),
        .last_lane (last_lane),
        .next_lane (next_lane)
    );

    burst_ctr #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_burst_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (cnt_clr_n),
        .ld_n      (ld_n),
        .inc       (inc),
        .ld_addr   (addr_in),
        .start_lane(start_lane),
        .last_lane (last_lane),
        .next_lane (next_lane),
        .addr_q    (addr_out),
        .lane_q    (lane_out)
    );

    rdback_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rdback_mux (
        .rdback  (rdback),
        .addr_q  (addr_out),
        .mem_q   (mem_q),
        .data_out(data_out)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Port-level properties of burst_addr_gen, attached by bind.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 36,
    parameter int LANE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ld_n,
    input logic              cnt_en_n,
    input logic              cnt_clr_n,
    input logic              rdback,
    input logic [1:0]        bus_mode,
    input logic [DATA_W-1:0] mem_q,
    input logic [ADDR_W-1:0] addr_out,
    input logic [LANE_W-1:0] lane_out,
    input logic [DATA_W-1:0] data_out
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic full_w;
    assign full_w = (bus_mode == 2'd0) || (bus_mode == 2'd3);

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr_n |=> addr_out == '0); // R2

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_n && !ld_n |=> addr_out == $past(addr_in)); // R3

    AST_FULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        full_w && cnt_clr_n && ld_n && !cnt_en_n && !rdback
        |=> addr_out == $past(addr_out) + 1'b1); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        full_w && cnt_clr_n && ld_n && !cnt_en_n && !rdback && addr_out == TOP_ADDR
        |=> addr_out == '0); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_n && ld_n && cnt_en_n |=> $stable(addr_out) && $stable(lane_out)); // R5

    AST_RDBACK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_n && ld_n && rdback |=> $stable(addr_out) && $stable(lane_out)); // R6

    AST_RDBACK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rdback |-> data_out[ADDR_W-1:0] == addr_out && data_out[DATA_W-1:ADDR_W] == '0); // R6

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rdback |-> data_out == mem_q); // R7

    AST_FULL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        full_w |-> lane_out == '0); // R10

    AST_HALF_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode == 2'd1 |-> lane_out[0] == 1'b0); // R8

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ld_n(ld_n),
    .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .rdback(rdback),
    .bus_mode(bus_mode), .mem_q(mem_q), .addr_out(addr_out),
    .lane_out(lane_out), .data_out(data_out)
);

// File: tb/test_burst_addr_gen.sv
// Bench: a behavioural reference model, compared on every clock.
module test_burst_addr_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] addr_in = '0;
    logic        ld_n = 1'b1;
    logic        cnt_en_n = 1'b1;
    logic        cnt_clr_n = 1'b1;
    logic        rdback = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic        big_end = 1'b0;
    logic [35:0] mem_q = '0;
    logic [13:0] addr_out;
    logic [1:0]  lane_out;
    logic [35:0] data_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int m_addr = 0;
    int m_pos = 0;

    burst_addr_gen i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ld_n(ld_n),
        .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .rdback(rdback),
        .bus_mode(bus_mode), .big_end(big_end), .mem_q(mem_q),
        .addr_out(addr_out), .lane_out(lane_out), .data_out(data_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int sub_count();
        if (bus_mode == 2'd1) return 2;
        if (bus_mode == 2'd2) return 4;
        return 1;
    endfunction

    function automatic int exp_lane();
        int n = sub_count();
        int stride = 4 / n;
        if (big_end) return (n - 1 - m_pos) * stride;
        return m_pos * stride;
    endfunction

    // Model update on each rising edge, from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n || !cnt_clr_n) begin
            m_addr = 0;
            m_pos  = 0;
        end else if (!ld_n) begin
            m_addr = int'(addr_in);
            m_pos  = 0;
        end else if (!cnt_en_n && !rdback) begin
            if (m_pos == sub_count() - 1) begin
                m_addr = (m_addr + 1) % 16384;
                m_pos  = 0;
            end else begin
                m_pos = m_pos + 1;
            end
        end
    end

    task automatic compare(input string tag);
        logic [35:0] exp_data;
        exp_data = rdback ? {22'd0, 14'(m_addr)} : mem_q;
        checks++;
        if (int'(addr_out) != m_addr) begin
            failures++;
            $display("FAIL %s addr_out actual=%h expected=%h", tag, addr_out, m_addr);
        end
        checks++;
        if (int'(lane_out) != exp_lane()) begin
            failures++;
            $display("FAIL %s lane_out actual=%0d expected=%0d", tag, lane_out, exp_lane());
        end
        checks++;
        if (data_out !== exp_data) begin
            failures++;
            $display("FAIL %s data_out actual=%h expected=%h", tag, data_out, exp_data);
        end
    endtask

    // One cycle: drive at negedge, let a rising edge pass, compare at negedge.
    task automatic step(input string tag, input logic l_n, input logic e_n,
                        input logic c_n, input logic rb, input logic [13:0] a);
        ld_n = l_n; cnt_en_n = e_n; cnt_clr_n = c_n; rdback = rb; addr_in = a;
        mem_q = {mem_q[34:0], mem_q[35] ^ mem_q[20]} + 36'h1_2345_6789;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic restart(input logic [1:0] mode, input logic be, input string tag);
        rst_n = 1'b0; bus_mode = mode; big_end = be;
        step(tag, 1'b1, 1'b1, 1'b1, 1'b0, 14'h0);
        step(tag, 1'b1, 1'b1, 1'b1, 1'b0, 14'h0);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, full width
        restart(2'd0, 1'b0, "R1");
        // R3: load, then count in full width (R4)
        step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 14'h1234);
        for (int i = 0; i < 5; i++) step("R4", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R5: idle hold
        for (int i = 0; i < 3; i++) step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 14'h2AAA);
        // R4: wrap at the top
        step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 14'h3FFD);
        for (int i = 0; i < 5; i++) step("R4", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R3: load wins over count
        step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 14'h0777);
        // R2: clear wins over load and count
        step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 14'h1555);
        step("R4", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R6: read-back freezes the counter, R7 data pass-through
        step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 14'h2BCD);
        for (int i = 0; i < 4; i++) step("R6", 1'b1, 1'b0, 1'b1, 1'b1, 14'h0);
        for (int i = 0; i < 2; i++) step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R10: endian ignored at full width
        restart(2'd0, 1'b1, "R10");
        for (int i = 0; i < 3; i++) step("R10", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R8: half width ascending
        restart(2'd1, 1'b0, "R8");
        step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 14'h0100);
        for (int i = 0; i < 7; i++) step("R8", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        // R11: load mid-sequence restarts the lane
        step("R11", 1'b0, 1'b0, 1'b1, 1'b0, 14'h0200);
        // R9: quarter width ascending, across the wrap
        restart(2'd2, 1'b0, "R9");
        step("R9", 1'b0, 1'b1, 1'b1, 1'b0, 14'h3FFF);
        for (int i = 0; i < 10; i++) step("R9", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        step("R6", 1'b1, 1'b0, 1'b1, 1'b1, 14'h0);
        step("R11", 1'b1, 1'b0, 1'b0, 1'b0, 14'h0);
        // R10: quarter width descending
        restart(2'd2, 1'b1, "R10");
        for (int i = 0; i < 9; i++) step("R10", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        step("R11", 1'b0, 1'b1, 1'b1, 1'b0, 14'h0042);
        // R10: half width descending
        restart(2'd1, 1'b1, "R10");
        for (int i = 0; i < 5; i++) step("R10", 1'b1, 1'b0, 1'b1, 1'b0, 14'h0);
        step("R11", 1'b1, 1'b1, 1'b0, 1'b0, 14'h0);
        // R1: reset again with a nonzero state
        step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 14'h1111);
        restart(2'd2, 1'b1, "R1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule